// File: doc/BRIEF.md
# Sectioned Carry-Lookahead Adder

This block is a purely combinational two-operand adder of parametrized width. The operands are cut into equal sections. Inside each section the bits are summed by a short ripple chain. Alongside each section, a lookahead unit works out the carry leaving that section. It uses only the per-bit generate terms (both operand bits set), the per-bit propagate terms (operand bits differ) and the carry entering the section. That carry then feeds the next section and the next lookahead unit, so the long carry path crosses one lookahead unit per section rather than one full adder per bit.

Beside the sum, the adder reports two flags. One is a carry flag for unsigned overflow. The other is an overflow flag for two's-complement results. To subtract, the surrounding logic inverts the second operand and raises the carry input. An operand width that is not a whole multiple of the section size stops elaboration.

Top module: `cla_sect_adder`

## Requirements
- R1: `sum_o` equals the low DATA_WIDTH bits of `opd_a + opd_b + carry_in`, taken as unsigned numbers.
- R2: `carry_flag` equals bit DATA_WIDTH of the unsigned sum `opd_a + opd_b + carry_in`.
- R3: `ovf_flag` is 1 exactly when `opd_a` and `opd_b` have the same most significant bit (bit DATA_WIDTH-1) and `sum_o` has a different one.
- R4: When the second operand is driven with `~B` and `carry_in` is 1, `sum_o` equals A-B modulo 2^DATA_WIDTH. In that case `carry_flag` is 1 exactly when A >= B as unsigned numbers.
- R5: The carry each lookahead unit produces for a section equals the carry out of that section's own ripple chain.
- R6: When every bit of a section propagates, the section passes its incoming carry through unchanged. With `opd_a` all ones, `opd_b` zero and `carry_in` 1, the result is a zero sum with `carry_flag` 1.
- R7: Driving `carry_in` to 1 raises the result by exactly one compared with `carry_in` 0, for the same operands.
- R8: Signed boundary operands set `ovf_flag` correctly. 0x7FFF+0x0001 gives `ovf_flag` 1 and `carry_flag` 0. 0x8000+0xFFFF gives `ovf_flag` 1 and `carry_flag` 1. 0xFFFF+0x0001 gives `ovf_flag` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_a | input | DATA_WIDTH | First operand |
| opd_b | input | DATA_WIDTH | Second operand (inverted outside the block for subtraction) |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | DATA_WIDTH | Sum of the operands and carry |
| carry_flag | output | 1 | Carry out of the most significant bit (unsigned overflow) |
| ovf_flag | output | 1 | Two's-complement overflow |

## Verification
Every time the inputs change, the embedded assertions check four things. The lookahead carry of each section must match that section's ripple carry. A fully propagating section must hand its incoming carry straight through. The combined flag and sum must equal the arithmetic total. The overflow flag must agree with a sign-based rule that does not use the internal carries. Only the bench can show the subtraction convention, the effect of the carry input compared across two applications, and the named corner operands. These are driven through directed cases mixed with seeded random operand pairs.

// File: rtl/cla_sect_pkg.sv
package cla_sect_pkg;
   function automatic int sect_count(input int width, input int sect);
      return width / sect;
   endfunction

   function automatic bit width_fits(input int width, input int sect);
      return (sect > 0) && (width >= sect) && ((width % sect) == 0);
   endfunction
endpackage

// File: rtl/cla_pg_gen.sv
module cla_pg_gen #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] op_x,
   input  logic [WIDTH-1:0] op_y,
   output logic [WIDTH-1:0] gen_o,
   output logic [WIDTH-1:0] prop_o
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign gen_o[i]  = op_x[i] & op_y[i];
      assign prop_o[i] = op_x[i] ^ op_y[i];
   end
endmodule

// File: rtl/cla_ripple_sect.sv
module cla_ripple_sect #(
   parameter int SECT = 4
) (
   input  logic [SECT-1:0] gen_i,
   input  logic [SECT-1:0] prop_i,
   input  logic            cin,
   output logic [SECT-1:0] sum_o,
   output logic            cout,
   output logic            c_top_in
);
   always_comb begin
      logic c;
      c        = cin;
      c_top_in = 1'b0;
      for (int i = 0; i < SECT; i++) begin
         if (i == SECT-1) c_top_in = c;
         sum_o[i] = prop_i[i] ^ c;
         c        = gen_i[i] | (prop_i[i] & c);
      end
      cout = c;
   end

   // Rebuild operand bits from gen/prop (a=g|p, b=g) and check arithmetic.
   always_comb begin
      AST_SECT_ARITH: assert ({cout, sum_o} ==
         ({1'b0, gen_i | prop_i} + {1'b0, gen_i} + {{SECT{1'b0}}, cin})); // R1
   end
endmodule

// File: rtl/cla_carry_gen.sv
module cla_carry_gen #(
   parameter int SECT = 4
) (
   input  logic [SECT-1:0] gen_i,
   input  logic [SECT-1:0] prop_i,
   input  logic            cin,
   output logic            cout
);
   // Triangular term array: row r holds r+1 product terms whose OR is carry r.
   for (genvar r = 0; r <= SECT; r++) begin : g_row
      logic [r:0] term;
      if (r == 0) begin : g_first
         assign term[0] = cin;
      end else begin : g_next
         assign term[0] = gen_i[r-1];
         for (genvar k = 1; k <= r; k++) begin : g_term
            assign term[k] = prop_i[r-1] & g_row[r-1].term[k-1];
         end
      end
   end

   assign cout = |g_row[SECT].term;

   always_comb begin
      if (&prop_i) begin
         AST_BYPASS_PASS: assert (cout == cin); // R6
      end
   end
endmodule

// File: rtl/cla_sect_adder.sv
module cla_sect_adder
   import cla_sect_pkg::*;
#(
   parameter int DATA_WIDTH = 16,
   parameter int BLOCK_SIZE = 4
) (
   input  logic [DATA_WIDTH-1:0] opd_a,
   input  logic [DATA_WIDTH-1:0] opd_b,
   input  logic                  carry_in,
   output logic [DATA_WIDTH-1:0] sum_o,
   output logic                  carry_flag,
   output logic                  ovf_flag
);
   localparam int NSEC = sect_count(DATA_WIDTH, BLOCK_SIZE);
   localparam int MSB  = DATA_WIDTH - 1;

   if (!width_fits(DATA_WIDTH, BLOCK_SIZE)) begin : g_bad_cfg
      $error("DATA_WIDTH must be a whole multiple of BLOCK_SIZE");
   end

   logic [DATA_WIDTH-1:0] gen_w, prop_w;
   logic [NSEC:0]         sec_c;
   logic [NSEC-1:0]       rip_c;
   logic [NSEC-1:0]       top_in;

   cla_pg_gen #(.WIDTH(DATA_WIDTH)) u_pg (
      .op_x   (opd_a),
      .op_y   (opd_b),
      .gen_o  (gen_w),
      .prop_o (prop_w)
   );

   assign sec_c[0] = carry_in;

   for (genvar s = 0; s < NSEC; s++) begin : g_sec
      localparam int LO = s * BLOCK_SIZE;

      cla_carry_gen #(.SECT(BLOCK_SIZE)) u_look (
         .gen_i  (gen_w[LO +: BLOCK_SIZE]),
         .prop_i (prop_w[LO +: BLOCK_SIZE]),
         .cin    (sec_c[s]),
         .cout   (sec_c[s+1])
      );

      cla_ripple_sect #(.SECT(BLOCK_SIZE)) u_rip (
         .gen_i    (gen_w[LO +: BLOCK_SIZE]),
         .prop_i   (prop_w[LO +: BLOCK_SIZE]),
         .cin      (sec_c[s]),
         .sum_o    (sum_o[LO +: BLOCK_SIZE]),
         .cout     (rip_c[s]),
         .c_top_in (top_in[s])
      );

      always_comb begin
         AST_SEC_CARRY_MATCH: assert (rip_c[s] == sec_c[s+1]); // R5
      end
   end

   assign carry_flag = sec_c[NSEC];
   assign ovf_flag   = top_in[NSEC-1] ^ sec_c[NSEC];

   always_comb begin
      AST_TOTAL_SUM: assert ({carry_flag, sum_o} ==
         ({1'b0, opd_a} + {1'b0, opd_b} + {{DATA_WIDTH{1'b0}}, carry_in})); // R2
      AST_OVF_SIGN: assert (ovf_flag ==
         ((opd_a[MSB] == opd_b[MSB]) && (sum_o[MSB] != opd_a[MSB]))); // R3
   end
endmodule

// File: tb/tb_cla_sect_adder.sv
module tb_cla_sect_adder;
   localparam int W = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic [W-1:0] a, b, s;
   logic         ci, cf, of;
   int total = 0;
   int bad   = 0;
   bit done  = 0;

   cla_sect_adder #(.DATA_WIDTH(W), .BLOCK_SIZE(4)) dut (
      .opd_a(a), .opd_b(b), .carry_in(ci),
      .sum_o(s), .carry_flag(cf), .ovf_flag(of)
   );

   function automatic logic [W:0] ref_total(input logic [W-1:0] x, y, input logic c);
      return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
   endfunction

   function automatic logic ref_ovf(input logic [W-1:0] x, y, input logic c);
      logic [W:0] t;
      t = ref_total(x, y, c);
      return (x[W-1] == y[W-1]) && (t[W-1] != x[W-1]);
   endfunction

   task automatic apply(input logic [W-1:0] x, y, input logic c);
      @(negedge clk);
      a = x; b = y; ci = c;
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h (a=%h b=%h ci=%b)", req, act, exp, a, b, ci);
      end
   endtask

   task automatic full(input string req, input logic [W-1:0] x, y, input logic c);
      logic [W:0] t;
      apply(x, y, c);
      t = ref_total(x, y, c);
      chk(req, {of, cf, s}, {ref_ovf(x, y, c), t});
   endtask

   initial begin
      #200000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [W:0] t0;
      void'($urandom(32'h1234_5678));
      a = '0; b = '0; ci = 1'b0;
      // reset-like initial state: zero inputs give zero outputs (R1)
      apply('0, '0, 1'b0);
      chk("R1 zero", {of, cf, s}, '0);
      full("R1 mixed", 16'h1234, 16'h4321, 1'b0);
      full("R2 carry out", 16'hF000, 16'h1000, 1'b0);
      // R6: all bits propagate, carry passes through every section
      apply(16'hFFFF, 16'h0000, 1'b1);
      chk("R6 bypass", {of, cf, s}, {2'b01, 16'h0000});
      full("R6 bypass no cin", 16'hAAAA, 16'h5555, 1'b0);
      // R8 sign boundaries
      apply(16'h7FFF, 16'h0001, 1'b0);
      chk("R8 pos ovf", {of, cf, s}, {2'b10, 16'h8000});
      apply(16'h8000, 16'hFFFF, 1'b0);
      chk("R8 neg ovf", {of, cf, s}, {2'b11, 16'h7FFF});
      apply(16'hFFFF, 16'h0001, 1'b0);
      chk("R8 no ovf", {of, cf, s}, {2'b01, 16'h0000});
      full("R3 neg ovf", 16'h8000, 16'h8000, 1'b0);
      // R4 subtraction
      apply(16'h0005, ~16'h0003, 1'b1);
      chk("R4 sub ge", {cf, s}, {1'b0, 1'b1, 16'h0002});
      apply(16'h0003, ~16'h0005, 1'b1);
      chk("R4 sub lt", {cf, s}, {1'b0, 1'b0, 16'hFFFE});
      apply(16'h1234, ~16'h1234, 1'b1);
      chk("R4 sub eq", {cf, s}, {1'b0, 1'b1, 16'h0000});
      // R7 carry-in adds one
      for (int i = 0; i < 40; i++) begin
         logic [W-1:0] x, y;
         x = W'($urandom); y = W'($urandom);
         apply(x, y, 1'b0);
         t0 = {cf, s};
         apply(x, y, 1'b1);
         chk("R7 cin plus one", {1'b0, cf, s}, {1'b0, t0 + 1'b1});
      end
      // R5 section carries seen through sums with carries crossing each section edge
      for (int k = 0; k < 4; k++) begin
         full("R5 edge carry", W'(16'h000F << (4*k)), W'(16'h0001 << (4*k)), 1'b0);
         full("R5 chain", W'(16'h000F << (4*k)), W'(16'h0000), 1'b1);
      end
      // random mix for R1/R2/R3
      for (int i = 0; i < 300; i++) begin
         logic [W-1:0] x, y;
         logic c;
         x = W'($urandom); y = W'($urandom); c = 1'($urandom);
         if (i % 10 == 0) x = 16'h7FFF;
         if (i % 10 == 1) y = 16'h8000;
         full("R1 R2 R3 random", x, y, c);
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule